// File: doc/BRIEF.md
# Dual-Edge Interrupt Capture Controller

This block gathers interrupt requests from five level-type sources on the codec side. The sources are a converter-done flag, two touch-panel sense lines and two clip detectors. Each source line comes in asynchronously and passes through a synchroniser. The block then watches the synchronised level for transitions. Software chooses, per source, whether a low-to-high transition, a high-to-low transition, both or neither should be captured.

A captured transition sets a sticky status bit. The status bit stays set until software clears it. Status and clear share one register address. A read returns the pending bits. A write with a one in a bit position clears that pending bit. The single interrupt line stays asserted as long as any pending bit is set.

All three registers use the same five-bit field in the upper part of a 16-bit word. The lower bits of every register read as zero.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the rising-enable, falling-enable and status registers all read 0x0000, and `irq` is low.
- R2: Address 0x2 holds the rising-edge enables and address 0x3 holds the falling-edge enables. Both read back bits 15:11 as written. Bits 10:0 of every register read as zero. Any address other than 0x2, 0x3 and 0x4 reads 0x0000.
- R3: Each source maps to one register bit. `src_in[0]` (converter ready) is bit 11, `src_in[1]` (touch X-plus) is bit 12, `src_in[2]` (touch X-minus) is bit 13, `src_in[3]` (telecom clip) is bit 14 and `src_in[4]` (audio clip) is bit 15.
- R4: A low-to-high transition of a source whose rising enable is 1 sets its status bit. A high-to-low transition of a source whose falling enable is 1 also sets its status bit. With both enables set, both directions set the bit.
- R5: A transition whose direction is not enabled for that source leaves its status bit at 0.
- R6: A status bit stays set after its source returns to its previous level, until software clears it.
- R7: At address 0x4, a read returns the status. A write of 1 in bit 11+i clears status bit i. A write of 0 leaves that bit unchanged.
- R8: When a captured transition and a clear of the same bit fall on the same clock edge, the bit stays set.
- R9: `irq` is high exactly while at least one status bit is set.
- R10: The status reflects a source change on the third rising clock edge after the change, and not on the second. Two edges are spent in the synchroniser and one in the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| src_in | input | 5 | Asynchronous source levels, bit i maps to register bit 11+i |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request, high while any status bit is pending |

## Verification
Several properties are checked on every cycle. A detected transition must show up in status on the next edge, even against a simultaneous clear. A cleared bit with no competing transition must drop. No pending bit may vanish without a clear. `irq` may only rise after a transition, and the low register bits must stay at zero.

Other behaviours are visible only through the bench's scenarios. These cover the mapping of each input pin to its bit position and the direction selection across many enable and level patterns. They also cover the exact three-edge latency and the readback of the enable registers.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  // Widths of the arithmetic helpers; instances must fit inside.
  localparam int unsigned HELPER_W = 16;

  // Which register an address selects.
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_RISE,
    SEL_FALL,
    SEL_STAT
  } reg_sel_e;

  // Transition events from the current and previous synchronised level.
  function automatic logic [HELPER_W-1:0] edge_events(
    input logic [HELPER_W-1:0] now_lvl,
    input logic [HELPER_W-1:0] old_lvl,
    input logic [HELPER_W-1:0] up_en,
    input logic [HELPER_W-1:0] down_en
  );
    logic [HELPER_W-1:0] went_up;
    logic [HELPER_W-1:0] went_down;
    went_up   = now_lvl & ~old_lvl;
    went_down = ~now_lvl & old_lvl;
    return (went_up & up_en) | (went_down & down_en);
  endfunction

  // Next pending state: a new event outranks a clear of the same bit.
  function automatic logic [HELPER_W-1:0] sticky_next(
    input logic [HELPER_W-1:0] cur,
    input logic [HELPER_W-1:0] set_v,
    input logic [HELPER_W-1:0] clr_v
  );
    return (cur & ~clr_v) | set_v;
  endfunction

  // Pull the source field out of a register word.
  function automatic logic [HELPER_W-1:0] take_field(
    input logic [31:0]  word,
    input int unsigned  lsb
  );
    return HELPER_W'(word >> lsb);
  endfunction

  // Address decode.
  function automatic reg_sel_e decode_addr(
    input logic [7:0] addr,
    input logic [7:0] a_rise,
    input logic [7:0] a_fall,
    input logic [7:0] a_stat
  );
    if (addr == a_rise)      return SEL_RISE;
    else if (addr == a_fall) return SEL_FALL;
    else if (addr == a_stat) return SEL_STAT;
    else                     return SEL_NONE;
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  // Chain of flops, one row per stage.
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/eirq_edge.sv
module eirq_edge #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  output logic [WIDTH-1:0] evt
);
  import eirq_pkg::*;

  // Previous synchronised level, reset low so a source held low is quiet.
  logic [WIDTH-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  assign evt = WIDTH'(edge_events(HELPER_W'(level), HELPER_W'(level_q),
                                  HELPER_W'(rise_en), HELPER_W'(fall_en)));

  // An event on a bit must coincide with a change of that bit's level.
  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~(level ^ level_q)) == '0));                             // R4

  // A bit with both enables at zero never raises an event.
  AST_EVT_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~(rise_en | fall_en)) == '0));                           // R5

endmodule

// File: rtl/eirq_status.sv
module eirq_status #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] status
);
  import eirq_pkg::*;

  logic [WIDTH-1:0] status_d;

  always_comb begin
    status_d = WIDTH'(sticky_next(HELPER_W'(status), HELPER_W'(set_vec),
                                  HELPER_W'(clr_vec)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  // Every event lands in status on the next edge, clear or not.
  AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R8

  // A clear with no competing event drops the bit.
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=>
      ((status & $past(clr_vec & ~set_vec)) == '0));                  // R7

  // A pending bit never falls without a clear.
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(status & ~clr_vec)) == '0));          // R6

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int unsigned NUM_SRC     = 5,
  parameter int unsigned FIELD_LSB   = 11,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_RISE   = 2,
  parameter int unsigned ADDR_FALL   = 3,
  parameter int unsigned ADDR_STAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import eirq_pkg::*;

  localparam int unsigned FIELD_MSB = FIELD_LSB + NUM_SRC - 1;

  // Decoded access and write field.
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] wr_field;
  logic               wr_rise;
  logic               wr_fall;
  logic               wr_stat;

  // Register state.
  logic [NUM_SRC-1:0] rise_en_q;
  logic [NUM_SRC-1:0] fall_en_q;
  logic [NUM_SRC-1:0] status_q;

  // Internal events brought out as named wires.
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] edge_evt;
  logic [NUM_SRC-1:0] clr_req;

  assign sel      = decode_addr(8'(reg_addr), 8'(ADDR_RISE), 8'(ADDR_FALL),
                                8'(ADDR_STAT));
  assign wr_field = NUM_SRC'(take_field(32'(reg_wdata), FIELD_LSB));
  assign wr_rise  = reg_we && (sel == SEL_RISE);
  assign wr_fall  = reg_we && (sel == SEL_FALL);
  assign wr_stat  = reg_we && (sel == SEL_STAT);
  assign clr_req  = wr_stat ? wr_field : '0;

  // Enable registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else begin
      if (wr_rise) rise_en_q <= wr_field;
      if (wr_fall) fall_en_q <= wr_field;
    end
  end

  eirq_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (src_in),
    .sync_out (src_sync)
  );

  eirq_edge #(
    .WIDTH (NUM_SRC)
  ) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (src_sync),
    .rise_en (rise_en_q),
    .fall_en (fall_en_q),
    .evt     (edge_evt)
  );

  eirq_status #(
    .WIDTH (NUM_SRC)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (edge_evt),
    .clr_vec (clr_req),
    .status  (status_q)
  );

  // Read mux: field placed at FIELD_LSB, all else zero.
  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_RISE: reg_rdata[FIELD_MSB:FIELD_LSB] = rise_en_q;
      SEL_FALL: reg_rdata[FIELD_MSB:FIELD_LSB] = fall_en_q;
      SEL_STAT: reg_rdata[FIELD_MSB:FIELD_LSB] = status_q;
      SEL_NONE: reg_rdata = '0;
    endcase
  end

  assign irq = |status_q;

  // irq can only go high one edge after a captured transition.
  AST_IRQ_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(edge_evt != '0));                          // R9

  // Unused low bits of every register read as zero.
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[FIELD_LSB-1:0] == '0));                               // R2

  // Enable registers keep their value while not written.
  AST_ENABLES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_rise || wr_fall) |=> $stable(rise_en_q) && $stable(fall_en_q)); // R2

endmodule

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_in = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // Fields: rise[19:15] fall[14:10] from[9:5] to[4:0]
  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    {5'b11111, 5'b00000, 5'b00000, 5'b11111},
    {5'b00000, 5'b11111, 5'b11111, 5'b00000},
    {5'b00000, 5'b11111, 5'b00000, 5'b11111},
    {5'b10101, 5'b01010, 5'b00000, 5'b11111},
    {5'b10101, 5'b01010, 5'b11111, 5'b00000},
    {5'b11111, 5'b11111, 5'b01100, 5'b10011},
    {5'b00110, 5'b00000, 5'b00101, 5'b01110},
    {5'b01000, 5'b10000, 5'b10000, 5'b01000}
  };

  task automatic check(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive_src(input logic [4:0] v);
    @(negedge clk);
    src_in = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Expected status from the requirement: enabled up or down moves per bit.
  function automatic logic [4:0] expect_bits(input logic [4:0] re, fe, a, b);
    logic [4:0] r;
    for (int i = 0; i < 5; i++)
      r[i] = (re[i] && !a[i] && b[i]) || (fe[i] && a[i] && !b[i]);
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R0 watchdog actual=0x0000 expected=0x0001");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h2, d); check(d == 16'h0, "R1 rise enables", d, 16'h0);
    rd(4'h3, d); check(d == 16'h0, "R1 fall enables", d, 16'h0);
    rd(4'h4, d); check(d == 16'h0, "R1 status", d, 16'h0);
    check(irq == 1'b0, "R1 irq", 16'(irq), 16'h0);

    // R2 readback and low bits
    wr(4'h2, 16'hFFFF); rd(4'h2, d); check(d == 16'hF800, "R2 rise readback", d, 16'hF800);
    wr(4'h3, 16'hA5A5); rd(4'h3, d); check(d == 16'hA000, "R2 fall readback", d, 16'hA000);
    rd(4'h5, d); check(d == 16'h0, "R2 other address", d, 16'h0);
    rd(4'h0, d); check(d == 16'h0, "R2 address zero", d, 16'h0);

    // Vector table: R4 R5 direction selection
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] re, fe, fr, to, ex;
      {re, fe, fr, to} = VEC[v];
      ex = expect_bits(re, fe, fr, to);
      wr(4'h2, 16'(re) << 11);
      wr(4'h3, 16'(fe) << 11);
      drive_src(fr);
      settle();
      wr(4'h4, 16'hF800);
      drive_src(to);
      settle();
      rd(4'h4, d);
      e = 16'(ex) << 11;
      check(d == e, (ex == '0) ? "R5 disabled direction" : "R4 enabled direction", d, e);
      check(irq == (ex != '0), "R9 irq follows status", 16'(irq), 16'(ex != '0));
    end

    // Clean up
    wr(4'h2, 16'h0); wr(4'h3, 16'h0);
    drive_src(5'b0); settle();
    wr(4'h4, 16'hF800);

    // R3 bit mapping, one source at a time
    wr(4'h2, 16'hF800);
    for (int i = 0; i < 5; i++) begin
      drive_src(5'(1 << i));
      settle();
      rd(4'h4, d);
      e = 16'(1) << (11 + i);
      check(d == e, "R3 source bit position", d, e);
      drive_src(5'b0);
      settle();
      wr(4'h4, 16'hF800);
    end

    // R10 latency: rising on src 1 (bit 12)
    drive_src(5'b00010);
    repeat (2) @(negedge clk);
    rd(4'h4, d); check(d == 16'h0, "R10 not yet after two edges", d, 16'h0);
    @(negedge clk);
    rd(4'h4, d); check(d == 16'h1000, "R10 set on third edge", d, 16'h1000);

    // R6 sticky after source returns
    drive_src(5'b0); settle();
    rd(4'h4, d); check(d == 16'h1000, "R6 sticky", d, 16'h1000);

    // R7 write zero keeps, write one clears
    wr(4'h4, 16'h0000);
    rd(4'h4, d); check(d == 16'h1000, "R7 zero write keeps", d, 16'h1000);
    wr(4'h4, 16'h1000);
    rd(4'h4, d); check(d == 16'h0, "R7 one write clears", d, 16'h0);
    check(irq == 1'b0, "R9 irq low when empty", 16'(irq), 16'h0);

    // R8 edge and clear on the same edge: bit 13 both directions
    wr(4'h2, 16'h2000); wr(4'h3, 16'h2000);
    drive_src(5'b00100); settle();
    rd(4'h4, d); check(d == 16'h2000, "R4 rise before collision", d, 16'h2000);
    drive_src(5'b00000);          // change before edge k
    @(negedge clk);               // after k
    @(negedge clk);               // after k+1: event seen by status next edge
    reg_addr = 4'h4; reg_wdata = 16'h2000; reg_we = 1'b1;
    @(negedge clk);               // after k+2: clear and event together
    reg_we = 1'b0;
    rd(4'h4, d); check(d == 16'h2000, "R8 event beats clear", d, 16'h2000);
    wr(4'h4, 16'h2000);
    rd(4'h4, d); check(d == 16'h0, "R8 later clear takes", d, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule